// File: doc/BRIEF.md
# Rotate-Mask-Merge Unit with MQ

This block performs the shift-right-long-immediate step of a fixed-point datapath. It keeps a companion word register, called MQ, alongside the datapath. Each accepted operation takes a 32-bit source word and a 5-bit immediate count N. The source is rotated right by N positions, which is the same as a left rotation by 32 minus N. A mask is built from N: N zero bits at the top, then ones. The output word takes its low 32-N bits from the rotated source and its top N bits from the MQ contents held before the operation. The rotated word, not the merged one, is written back into MQ. Two operations in a row can therefore carry bits from one word into the next, which is how a shift across more than one word is built.

When the record input is set, a 4-bit condition field is also updated. It holds a signed comparison of the output word against zero, plus a copy of the incoming summary-overflow flag. When the record input is clear, the field keeps its value. The block never produces overflow or exception-register updates. Results are registered: the output word, MQ and the condition field all change one clock after the valid strobe.

Top module: `rmm_unit`

## Requirements
- R1: While rst_n is low, and after it is released, result_q, mq_q and cond_q read zero until the first accepted operation.
- R2: One cycle after op_valid is high, mq_q equals src_word rotated right by shamt positions, so bit i of mq_q is src_word bit (i+shamt) mod 32.
- R3: One cycle after op_valid is high, bits [31-shamt:0] of result_q equal the same bits of the rotated source, and the top shamt bits of result_q equal the top shamt bits of mq_q as it stood before the operation.
- R4: With shamt = 0, the mask is all ones, so result_q and mq_q both equal src_word.
- R5: One cycle after op_valid and rec_en are both high, cond_q = {LT, GT, EQ, SO} with LT at bit 3 and SO at bit 0. LT is set when result_q is negative as a two's-complement value, GT when it is positive, EQ when it is zero, and exactly one of the three is set.
- R6: An accepted operation with rec_en low leaves cond_q unchanged.
- R7: A cycle with op_valid low leaves result_q, mq_q and cond_q unchanged, whatever the other inputs are.
- R8: In a recorded operation, bit 0 of cond_q copies so_in.
- R9: Back-to-back operations chain. The second operation merges with the MQ value written by the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_valid | input | 1 | Accept an operation on this edge |
| src_word | input | 32 | Source word to rotate |
| shamt | input | 5 | Immediate count N |
| rec_en | input | 1 | Update the condition field |
| so_in | input | 1 | Incoming summary-overflow flag |
| result_q | output | 32 | Registered merged output word |
| mq_q | output | 32 | MQ register contents |
| cond_q | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The output word, MQ and the condition field are all due exactly one rising edge after the cycle in which op_valid is high. The bench drives each operation on a falling edge and releases op_valid on the next falling edge. It compares all three outputs at that same falling edge, half a period after the capturing edge. Hold behaviour is checked after an idle or non-recording cycle, with inputs changed to values that would alter the outputs if they were taken. The expected MQ is carried in a bench model, so chained operations are checked against the previous expected value.

// File: rtl/rmm_pkg.sv
package rmm_pkg;
  parameter int unsigned DATA_W = 32;
  localparam int unsigned SHAMT_W = $clog2(DATA_W);

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;
endpackage

// File: rtl/rmm_rotator.sv
module rmm_rotator #(
  parameter int unsigned W   = 32,
  parameter int unsigned SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   dout
);
  logic [W-1:0] stg [0:SHW];

  assign stg[0] = din;

  // logarithmic right rotator, stage k rotates by 2**k when amt[k] is set
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int unsigned D = 1 << k;
    assign stg[k+1] = amt[k] ? {stg[k][D-1:0], stg[k][W-1:D]} : stg[k];
  end

  assign dout = stg[SHW];
endmodule

// File: rtl/rmm_mask_gen.sv
module rmm_mask_gen #(
  parameter int unsigned W   = 32,
  parameter int unsigned SHW = $clog2(W)
) (
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   mask
);
  // bit i is kept from the rotated word when i < W - amt
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [SHW:0] LIM = SHW'(W - 1 - i) + 1'b0;
    assign mask[i] = ({1'b0, amt} <= LIM);
  end
endmodule

// File: rtl/rmm_cond_gen.sv
module rmm_cond_gen #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]   value,
  input  logic           so_flag,
  output rmm_pkg::cond_t cond
);
  logic is_zero;

  assign is_zero = (value == '0);

  always_comb begin
    cond.lt = value[W-1];
    cond.eq = is_zero;
    cond.gt = ~value[W-1] & ~is_zero;
    cond.so = so_flag;
  end
endmodule

// File: rtl/rmm_unit.sv
module rmm_unit #(
  parameter int unsigned W   = rmm_pkg::DATA_W,
  parameter int unsigned SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [W-1:0]   src_word,
  input  logic [SHW-1:0] shamt,
  input  logic           rec_en,
  input  logic           so_in,
  output logic [W-1:0]   result_q,
  output logic [W-1:0]   mq_q,
  output logic [3:0]     cond_q
);
  import rmm_pkg::*;

  logic [W-1:0] rot_w;
  logic [W-1:0] mask_w;
  logic [W-1:0] merged_w;
  cond_t        cond_w;

  logic [W-1:0] result_d;
  logic [W-1:0] mq_d;
  logic [3:0]   cond_d;
  logic         data_en;
  logic         cond_en;

  rmm_rotator #(.W(W), .SHW(SHW)) u_rot (
    .din  (src_word),
    .amt  (shamt),
    .dout (rot_w)
  );

  rmm_mask_gen #(.W(W), .SHW(SHW)) u_mask (
    .amt  (shamt),
    .mask (mask_w)
  );

  // top bits come from the MQ contents held before this operation
  assign merged_w = (rot_w & mask_w) | (mq_q & ~mask_w);

  rmm_cond_gen #(.W(W)) u_cond (
    .value   (merged_w),
    .so_flag (so_in),
    .cond    (cond_w)
  );

  // next-state
  always_comb begin
    data_en  = op_valid;
    cond_en  = op_valid & rec_en;
    result_d = data_en ? merged_w : result_q;
    mq_d     = data_en ? rot_w    : mq_q;
    cond_d   = cond_en ? cond_w   : cond_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      mq_q     <= '0;
      cond_q   <= '0;
    end else begin
      result_q <= result_d;
      mq_q     <= mq_d;
      cond_q   <= cond_d;
    end
  end
endmodule

// File: rtl/rmm_checker.sv
module rmm_checker #(
  parameter int unsigned W   = 32,
  parameter int unsigned SHW = $clog2(W)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           op_valid,
  input logic [W-1:0]   src_word,
  input logic [SHW-1:0] shamt,
  input logic           rec_en,
  input logic           so_in,
  input logic [W-1:0]   result_q,
  input logic [W-1:0]   mq_q,
  input logic [3:0]     cond_q
);
  function automatic logic [W-1:0] chk_ror(input logic [W-1:0] v, input logic [SHW-1:0] n);
    logic [2*W-1:0] dbl;
    dbl = {v, v} >> n;
    return dbl[W-1:0];
  endfunction

  function automatic logic [W-1:0] chk_mask(input logic [SHW-1:0] n);
    return {W{1'b1}} >> n;
  endfunction

  // R2
  a_r2_mq_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> mq_q == chk_ror($past(src_word), $past(shamt)));

  // R3 low part equals the rotated word now held in MQ
  a_r3_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> ((result_q ^ mq_q) & chk_mask($past(shamt))) == '0);

  // R3 high part comes from the old MQ
  a_r3_high_bits: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> ((result_q ^ $past(mq_q)) & ~chk_mask($past(shamt))) == '0);

  // R5
  a_r5_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && rec_en) |=> $countones(cond_q[3:1]) == 1);

  a_r5_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && rec_en) |=> (cond_q[3] == result_q[W-1]) && (cond_q[1] == (result_q == '0)));

  // R6
  a_r6_cond_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !rec_en) |=> $stable(cond_q));

  // R7
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(result_q) && $stable(mq_q) && $stable(cond_q));

  // R8
  a_r8_so_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && rec_en) |=> cond_q[0] == $past(so_in));
endmodule

bind rmm_unit rmm_checker #(.W(W), .SHW(SHW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .src_word (src_word),
  .shamt    (shamt),
  .rec_en   (rec_en),
  .so_in    (so_in),
  .result_q (result_q),
  .mq_q     (mq_q),
  .cond_q   (cond_q)
);

// File: tb/tb_rmm_unit.sv
module tb_rmm_unit;
  localparam int W = 32;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [31:0] src_word;
  logic [4:0]  shamt;
  logic        rec_en;
  logic        so_in;
  logic [31:0] result_q;
  logic [31:0] mq_q;
  logic [3:0]  cond_q;

  int n_tests;
  int n_fail;
  logic [31:0] m_res;
  logic [31:0] m_mq;
  logic [3:0]  m_cond;

  rmm_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .src_word(src_word),
    .shamt(shamt), .rec_en(rec_en), .so_in(so_in),
    .result_q(result_q), .mq_q(mq_q), .cond_q(cond_q)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] ref_ror(input logic [31:0] v, input int n);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[(i + n) % 32];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " result"}, result_q, m_res);
    chk({req, " mq"}, mq_q, m_mq);
    chk({req, " cond"}, {28'd0, cond_q}, {28'd0, m_cond});
  endtask

  // one accepted operation; outputs sampled on the next falling edge
  task automatic do_op(input logic [31:0] s, input int n, input logic rec, input logic so);
    logic [31:0] rot;
    logic [31:0] msk;
    @(negedge clk);
    op_valid = 1'b1; src_word = s; shamt = 5'(n); rec_en = rec; so_in = so;
    rot = ref_ror(s, n);
    msk = 32'hFFFF_FFFF;
    for (int i = 0; i < 32; i++) if (i >= 32 - n) msk[i] = 1'b0;
    m_res = (rot & msk) | (m_mq & ~msk);
    m_mq  = rot;
    if (rec)
      m_cond = {m_res[31], ~m_res[31] & (m_res != 0), (m_res == 0), so};
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; op_valid = 1'b0; src_word = '0; shamt = '0; rec_en = 1'b0; so_in = 1'b0;
    repeat (3) @(negedge clk);
    m_res = '0; m_mq = '0; m_cond = '0;
    chk_all("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_all("R1 after release");
  endtask

  task automatic t_example_plain;
    do_op(32'h1111_1111, 0, 1'b0, 1'b0);   // load MQ
    do_op(32'h9000_300F, 4, 1'b0, 1'b0);
    chk("R3 example result", result_q, 32'h1900_0300);
    chk("R2 example mq", mq_q, 32'hF900_0300);
  endtask

  task automatic t_example_record;
    do_op(32'hFFFF_FFFF, 0, 1'b0, 1'b0);
    do_op(32'hB004_3000, 4, 1'b1, 1'b0);
    chk("R3 recorded result", result_q, 32'hFB00_4300);
    chk("R2 recorded mq", mq_q, 32'h0B00_4300);
    chk("R5 recorded cond", {28'd0, cond_q}, 32'h8);
  endtask

  task automatic t_zero_shift;
    do_op(32'h5A5A_0F0F, 0, 1'b1, 1'b0);
    chk("R4 result equals source", result_q, 32'h5A5A_0F0F);
    chk("R4 mq equals source", mq_q, 32'h5A5A_0F0F);
    chk("R5 positive gives GT", {28'd0, cond_q}, 32'h4);
    do_op(32'h0000_0000, 0, 1'b1, 1'b1);
    chk("R5 zero gives EQ, R8 SO copied", {28'd0, cond_q}, 32'h3);
  endtask

  task automatic t_sweep;
    for (int n = 0; n < 32; n++) begin
      do_op(32'hA5C3_1E77 ^ (32'h0101_0101 * n), n, n[0], n[1]);
      chk_all("R2 R3 R9 sweep");
    end
  endtask

  task automatic t_no_record;
    do_op(32'h8000_0001, 0, 1'b1, 1'b1);   // cond = LT|SO
    do_op(32'h0000_0000, 0, 1'b0, 1'b0);   // would be EQ if recorded
    chk("R6 cond kept without record", {28'd0, cond_q}, 32'h9);
    chk_all("R6 other outputs");
  endtask

  task automatic t_idle;
    do_op(32'h1234_5678, 12, 1'b1, 1'b0);
    @(negedge clk);
    src_word = 32'hDEAD_BEEF; shamt = 5'd7; rec_en = 1'b1; so_in = 1'b1;
    repeat (3) @(negedge clk);
    chk_all("R7 idle hold");
  endtask

  task automatic t_chain;
    do_op(32'hCAFE_F00D, 8, 1'b0, 1'b0);
    do_op(32'h1357_9BDF, 8, 1'b0, 1'b0);
    chk("R9 chained result", result_q, 32'h0D13_579B);
    chk("R9 chained mq", mq_q, 32'hDF13_579B);
  endtask

  initial begin
    n_tests = 0; n_fail = 0;
    t_reset();
    t_example_plain();
    t_example_record();
    t_zero_shift();
    t_sweep();
    t_no_record();
    t_idle();
    t_chain();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule